// File: doc/BRIEF.md
# Boot Program Counter and Reset Sequencer

This block drives the fetch address for a small 32-bit core that completes one fixed-length instruction every cycle. While the synchronous, active-high reset is held, a strap input chooses one of two restart addresses. That address goes into the program counter and stays there, and fetch remains off. The strap is only read during reset.

A parameter sets what happens after reset is released. In direct mode, fetch starts at the restart address on the next cycle. In vector mode, the restart address is the base of a two-word table. The block reads the first word and publishes it as the initial stack pointer. It then reads the second word and loads it into the program counter. Fetch starts in the cycle after that second word arrives. Table reads go through a simple request port. The response arrives at the earliest one cycle after the request, and the block waits as long as the response takes.

Top module: `boot_pc`

## Requirements
- R1: While `rst` is high at a clock edge, `fetch_valid`, `rd_req` and `sp_load` are low after that edge.
- R2: While `rst` is high, `fetch_addr` shows the restart address: 0x0000_0000 when `boot_strap` is 1 and 0x0000_FFF0 when `boot_strap` is 0.
- R3: `boot_strap` is sampled only while `rst` is high, and the last value seen before release wins. Changes after release do not move `fetch_addr` or `rd_addr`.
- R4: In direct mode (`VECTOR_MODE`=0), `fetch_valid` is high after the first clock edge with `rst` low, with `fetch_addr` equal to the restart address. `rd_req` never rises.
- R5: While `fetch_valid` stays high, `fetch_addr` rises by 4 every cycle, wrapping modulo 2^32.
- R6: In vector mode, `rd_req` is high for exactly one cycle, with `rd_addr` equal to the restart address, in the cycle after the first edge with `rst` low. `fetch_valid` stays low.
- R7: After a request, the block issues no new request and changes no output until `rd_valid` is sampled high. `rd_valid` in the request cycle itself is ignored.
- R8: The first returned word appears on `sp_value`, with `sp_load` high for one cycle, in the cycle after it is returned.
- R9: The second request goes out in that same cycle at restart address + 4. The word returned for it is the first `fetch_addr`, with `fetch_valid` rising the cycle after `rd_valid`.
- R10: `rd_req` and `fetch_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_strap | input | 1 | Restart address select (1: 0x0, 0: 0xFFF0) |
| rd_req | output | 1 | Table read request, one-cycle pulse |
| rd_addr | output | ADDR_W | Table read address |
| rd_data | input | ADDR_W | Returned table word |
| rd_valid | input | 1 | `rd_data` valid this cycle |
| fetch_valid | output | 1 | Fetch enabled at `fetch_addr` |
| fetch_addr | output | ADDR_W | Current program counter |
| sp_load | output | 1 | One-cycle strobe for `sp_value` |
| sp_value | output | ADDR_W | Initial stack pointer from the table |

## Verification
The bench runs every strap value against response stalls of zero to three cycles. A design that captured data early, or issued a second request while waiting, would show a shifted `sp_value` or stray `rd_req` pulses. The strap is flipped both during reset and after release. A design that kept sampling it would jump the PC in mid-run, and one that latched it early would start from the wrong address. An entry word near the top of the address space checks that the +4 step wraps through zero. A direct-mode instance runs alongside and confirms that it fetches from the first post-reset cycle and never touches the read port.

// File: rtl/boot_pc_pkg.sv
package boot_pc_pkg;

    typedef enum logic [1:0] {
        ST_RESET  = 2'd0,
        ST_VEC_SP = 2'd1,
        ST_VEC_PC = 2'd2,
        ST_RUN    = 2'd3
    } boot_state_e;

endpackage

// File: rtl/boot_pc_restart_sel.sv
module boot_pc_restart_sel #(
    parameter int              ADDR_W            = 32,
    parameter logic [ADDR_W-1:0] BOOT_ADDR_STRAP_HI = '0,
    parameter logic [ADDR_W-1:0] BOOT_ADDR_STRAP_LO = '0
) (
    input  logic              strap,
    output logic [ADDR_W-1:0] restart_addr
);

    // Strap high selects the low-memory restart, strap low the alternate one.
    always_comb begin
        restart_addr = strap ? BOOT_ADDR_STRAP_HI : BOOT_ADDR_STRAP_LO;
    end

endmodule

// File: rtl/boot_pc_ctrl.sv
module boot_pc_ctrl
    import boot_pc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter bit VECTOR_MODE = 1'b1,
    parameter int INSTR_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] restart_addr,
    input  logic [ADDR_W-1:0] rd_data,
    input  logic              rd_valid,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              sp_load,
    output logic [ADDR_W-1:0] sp_value
);

    localparam logic [ADDR_W-1:0] PC_STEP    = ADDR_W'(INSTR_BYTES);
    localparam logic [ADDR_W-1:0] WORD_STEP  = ADDR_W'(ADDR_W / 8);
    localparam boot_state_e       FIRST_STATE = VECTOR_MODE ? ST_VEC_SP : ST_RUN;

    typedef struct packed {
        boot_state_e       st;
        logic              pend;
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] sp;
        logic              sp_ld;
    } ctrl_t;

    ctrl_t ctrl_d;
    ctrl_t ctrl_q;

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.sp_ld = 1'b0;
        if (rst) begin
            ctrl_d.st   = ST_RESET;
            ctrl_d.pend = 1'b0;
            ctrl_d.pc   = restart_addr;
            ctrl_d.sp   = '0;
        end else begin
            unique case (ctrl_q.st)
                ST_RESET: begin
                    ctrl_d.pend = 1'b0;
                    ctrl_d.st   = FIRST_STATE;
                end
                ST_VEC_SP: begin
                    if (!ctrl_q.pend) begin
                        ctrl_d.pend = 1'b1;
                    end else if (rd_valid) begin
                        ctrl_d.sp    = rd_data;
                        ctrl_d.sp_ld = 1'b1;
                        ctrl_d.pend  = 1'b0;
                        ctrl_d.st    = ST_VEC_PC;
                    end
                end
                ST_VEC_PC: begin
                    if (!ctrl_q.pend) begin
                        ctrl_d.pend = 1'b1;
                    end else if (rd_valid) begin
                        ctrl_d.pc   = rd_data;
                        ctrl_d.pend = 1'b0;
                        ctrl_d.st   = ST_RUN;
                    end
                end
                ST_RUN: begin
                    ctrl_d.pc = ctrl_q.pc + PC_STEP;
                end
                default: begin
                    ctrl_d.st = ST_RESET;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        ctrl_q <= ctrl_d;
    end

    // The table base is the held restart address; the second word sits one word above.
    assign rd_req      = ((ctrl_q.st == ST_VEC_SP) || (ctrl_q.st == ST_VEC_PC)) && !ctrl_q.pend;
    assign rd_addr     = (ctrl_q.st == ST_VEC_PC) ? (ctrl_q.pc + WORD_STEP) : ctrl_q.pc;
    assign fetch_valid = (ctrl_q.st == ST_RUN);
    assign fetch_addr  = ctrl_q.pc;
    assign sp_load     = ctrl_q.sp_ld;
    assign sp_value    = ctrl_q.sp;

endmodule

// File: rtl/boot_pc.sv
module boot_pc #(
    parameter int                ADDR_W             = 32,
    parameter bit                VECTOR_MODE        = 1'b1,
    parameter int                INSTR_BYTES        = 4,
    parameter logic [ADDR_W-1:0] BOOT_ADDR_STRAP_HI = 'h0000,
    parameter logic [ADDR_W-1:0] BOOT_ADDR_STRAP_LO = 'hFFF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_strap,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] rd_data,
    input  logic              rd_valid,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              sp_load,
    output logic [ADDR_W-1:0] sp_value
);

    logic [ADDR_W-1:0] restart_addr;

    boot_pc_restart_sel #(
        .ADDR_W            (ADDR_W),
        .BOOT_ADDR_STRAP_HI(BOOT_ADDR_STRAP_HI),
        .BOOT_ADDR_STRAP_LO(BOOT_ADDR_STRAP_LO)
    ) u_restart_sel (
        .strap       (boot_strap),
        .restart_addr(restart_addr)
    );

    boot_pc_ctrl #(
        .ADDR_W     (ADDR_W),
        .VECTOR_MODE(VECTOR_MODE),
        .INSTR_BYTES(INSTR_BYTES)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .restart_addr(restart_addr),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .sp_load     (sp_load),
        .sp_value    (sp_value)
    );

endmodule

// File: rtl/boot_pc_checker.sv
module boot_pc_checker #(
    parameter int                ADDR_W             = 32,
    parameter bit                VECTOR_MODE        = 1'b1,
    parameter int                INSTR_BYTES        = 4,
    parameter logic [ADDR_W-1:0] BOOT_ADDR_STRAP_HI = 'h0000,
    parameter logic [ADDR_W-1:0] BOOT_ADDR_STRAP_LO = 'hFFF0
) (
    input logic              clk,
    input logic              rst,
    input logic              boot_strap,
    input logic              rd_req,
    input logic              rd_valid,
    input logic              fetch_valid,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic              sp_load
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    logic was_rst_q   = 1'b0;
    logic was_strap_q = 1'b0;

    always_ff @(posedge clk) begin
        was_rst_q   <= rst;
        was_strap_q <= boot_strap;
    end

    always @(negedge clk) begin
        if (was_rst_q) begin
            assert_reset_quiet_R1: assert (!fetch_valid && !rd_req && !sp_load);
            assert_restart_addr_R2: assert (fetch_addr ==
                (was_strap_q ? BOOT_ADDR_STRAP_HI : BOOT_ADDR_STRAP_LO));
        end
    end

    assert_step_R5: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && $past(fetch_valid)) |-> (fetch_addr == $past(fetch_addr) + STEP));

    assert_run_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        $past(fetch_valid) |-> fetch_valid);

    assert_single_req_R7: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    assert_sp_after_data_R8: assert property (@(posedge clk) disable iff (rst)
        sp_load |-> $past(rd_valid));

    assert_entry_after_data_R9: assert property (@(posedge clk) disable iff (rst)
        (VECTOR_MODE && $rose(fetch_valid)) |-> $past(rd_valid));

    assert_req_fetch_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && fetch_valid));

    assert_direct_no_req_R4: assert property (@(posedge clk) disable iff (rst)
        !VECTOR_MODE |-> !rd_req);

endmodule

bind boot_pc boot_pc_checker #(
    .ADDR_W            (ADDR_W),
    .VECTOR_MODE       (VECTOR_MODE),
    .INSTR_BYTES       (INSTR_BYTES),
    .BOOT_ADDR_STRAP_HI(BOOT_ADDR_STRAP_HI),
    .BOOT_ADDR_STRAP_LO(BOOT_ADDR_STRAP_LO)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .boot_strap (boot_strap),
    .rd_req     (rd_req),
    .rd_valid   (rd_valid),
    .fetch_valid(fetch_valid),
    .fetch_addr (fetch_addr),
    .sp_load    (sp_load)
);

// File: tb/boot_pc_tb.sv
`timescale 1ns/1ps
module boot_pc_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap = 1'b1;
    logic        rd_req, fetch_valid, sp_load;
    logic [31:0] rd_addr, fetch_addr, sp_value;
    logic [31:0] rd_data = '0;
    logic        rd_valid = 1'b0;
    logic        d_rd_req, d_fetch_valid, d_sp_load;
    logic [31:0] d_rd_addr, d_fetch_addr, d_sp_value;

    int n_chk  = 0;
    int n_fail = 0;
    int stall  = 0;
    int seed   = 0;
    bit wrap_mode = 1'b0;
    int since_rel = 0;

    always #2.5 clk = ~clk;

    boot_pc #(.VECTOR_MODE(1'b1)) u_dut (
        .clk(clk), .rst(rst), .boot_strap(strap),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .sp_load(sp_load), .sp_value(sp_value)
    );

    boot_pc #(.VECTOR_MODE(1'b0)) u_dut_dir (
        .clk(clk), .rst(rst), .boot_strap(strap),
        .rd_req(d_rd_req), .rd_addr(d_rd_addr), .rd_data(32'h0), .rd_valid(1'b0),
        .fetch_valid(d_fetch_valid), .fetch_addr(d_fetch_addr),
        .sp_load(d_sp_load), .sp_value(d_sp_value)
    );

    function automatic logic [31:0] exp_restart(input bit s);
        return s ? 32'h0000_0000 : 32'h0000_FFF0;
    endfunction

    function automatic logic [31:0] word_at(input logic [31:0] a);
        if (wrap_mode && a[2]) return 32'hFFFF_FFF0;
        return 32'h2000_0000 + {a[27:0], 4'h0} + (32'(seed) << 12);
    endfunction

    // Table memory: answers a request after one cycle plus `stall` extra cycles.
    logic        mem_busy = 1'b0;
    int          mem_wait = 0;
    logic [31:0] mem_addr = '0;
    always @(negedge clk) begin
        rd_valid = 1'b0;
        if (rst) begin
            mem_busy = 1'b0;
        end else begin
            if (mem_busy) begin
                if (mem_wait == 0) begin
                    rd_valid = 1'b1;
                    rd_data  = word_at(mem_addr);
                    mem_busy = 1'b0;
                end else begin
                    mem_wait--;
                end
            end
            if (rd_req) begin
                mem_busy = 1'b1;
                mem_addr = rd_addr;
                mem_wait = stall;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        since_rel++;
    endtask

    task automatic do_reset(input bit s_first, input bit s);
        rst   = 1'b1;
        strap = s_first;
        repeat (3) @(negedge clk);
        chk(!fetch_valid && !rd_req && !sp_load, "R1 vector quiet in reset",
            {29'd0, fetch_valid, rd_req, sp_load}, 32'd0);
        chk(!d_fetch_valid && !d_rd_req && !d_sp_load, "R1 direct quiet in reset",
            {29'd0, d_fetch_valid, d_rd_req, d_sp_load}, 32'd0);
        chk(fetch_addr == exp_restart(s_first), "R2 restart address", fetch_addr, exp_restart(s_first));
        strap = s;
        @(negedge clk);
        chk(fetch_addr == exp_restart(s), "R3 last strap in reset wins", fetch_addr, exp_restart(s));
        chk(d_fetch_addr == exp_restart(s), "R2 direct restart address", d_fetch_addr, exp_restart(s));
        rst       = 1'b0;
        since_rel = 0;
    endtask

    task automatic run_vec(input bit s, input int st);
        logic [31:0] base;
        logic [31:0] exp_pc;
        base  = exp_restart(s);
        stall = st;
        tick();
        chk(rd_req && !fetch_valid, "R6 first request", {31'd0, rd_req}, 32'd1);
        chk(rd_addr == base, "R6 request address", rd_addr, base);
        chk(d_fetch_valid && d_fetch_addr == base, "R4 direct first fetch", d_fetch_addr, base);
        strap = ~s;
        tick();
        chk(!rd_req, "R6 request is one pulse", {31'd0, rd_req}, 32'd0);
        for (int i = 0; i < st; i++) begin
            tick();
            chk(!rd_req && !sp_load, "R7 wait for stack word", {30'd0, rd_req, sp_load}, 32'd0);
        end
        tick();
        chk(sp_load, "R8 sp strobe", {31'd0, sp_load}, 32'd1);
        chk(sp_value == word_at(base), "R8 sp value", sp_value, word_at(base));
        chk(rd_req && rd_addr == base + 32'd4, "R9 second request", rd_addr, base + 32'd4);
        tick();
        chk(!sp_load && !rd_req, "R8 strobe one cycle", {30'd0, sp_load, rd_req}, 32'd0);
        for (int i = 0; i < st; i++) begin
            tick();
            chk(!rd_req && !fetch_valid, "R7 wait for entry word", {30'd0, rd_req, fetch_valid}, 32'd0);
        end
        tick();
        exp_pc = word_at(base + 32'd4);
        chk(fetch_valid && fetch_addr == exp_pc, "R9 first fetch at entry", fetch_addr, exp_pc);
        strap = s;
        for (int i = 0; i < 6; i++) begin
            tick();
            exp_pc = exp_pc + 32'd4;
            chk(fetch_valid && fetch_addr == exp_pc, "R5 step by four", fetch_addr, exp_pc);
            chk(!(rd_req && fetch_valid), "R10 request and fetch exclusive", {31'd0, rd_req}, 32'd0);
        end
        chk(sp_value == word_at(base), "R8 sp holds", sp_value, word_at(base));
        chk(d_fetch_valid && d_fetch_addr == base + 32'(4 * (since_rel - 1)),
            "R3 direct pc unmoved by strap", d_fetch_addr, base + 32'(4 * (since_rel - 1)));
        chk(!d_rd_req && !d_sp_load, "R4 direct read port idle", {30'd0, d_rd_req, d_sp_load}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            for (int st = 0; st < 4; st++) begin
                seed = s * 4 + st;
                do_reset(~s[0], s[0]);
                run_vec(s[0], st);
            end
        end
        wrap_mode = 1'b1;
        for (int s = 0; s < 2; s++) begin
            seed = 9 + s;
            do_reset(s[0], s[0]);
            run_vec(s[0], 1);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule